// File: doc/BRIEF.md
# CAN Frame Field Parser

This block sits behind a CAN bit sampler. It takes one sampled bus level per `bit_valid` pulse and removes the stuff bits inserted by the transmitter. It then counts the position of each remaining bit inside the frame and pulls out every field of a base-format or extended-format data frame. The fields are the identifiers, the control bits, the data length code, the data bytes, the 15-bit CRC sequence, the acknowledge slot and the end of frame. Each field is presented on its own output bus, together with a one-cycle strobe. After the last end-of-frame bit, the parser reports completion and waits for the next start of frame.

The frame layout is driven by position. Up to bit 13 both formats match. The identifier-extension bit then selects one of two header layouts. The received length code then moves the start of the CRC and trailer fields. Malformed input raises one of three error strobes: a recessive start bit, a broken stuffing rule, or a dominant level where a fixed recessive bit is required. The CRC is reported but not checked. Error frames and overload frames are not decoded.

Top module: `can_field_parser`

## Requirements
- R1: When idle, a dominant (0) bit starts a frame. A recessive (1) bit in the start position pulses `err_sof` for one cycle and is discarded. The parser keeps waiting for a start bit. After reset all strobes are low.
- R2: Frame bits 1 to 11, sent MSB first, are reported on `base_id` with a one-cycle `id_valid` pulse.
- R3: In the base format (bit 13 dominant), `ctrl_valid` pulses after bit 18. It carries `ctrl_ide`=0, `ctrl_rtr` equal to bit 12, and `ctrl_rsvd[0]` equal to bit 14 (either level accepted), with `ctrl_rsvd[1]`=0.
- R4: In the extended format (bit 13 recessive), `ext_valid` pulses after bit 31. `ext_id` holds bits 14 to 31, and `full_id` equals `base_id`·2^18 + `ext_id`. `ctrl_valid` follows after bit 38 with `ctrl_ide`=1, `ctrl_rtr` equal to bit 32, `ctrl_rsvd[1]` equal to bit 33 and `ctrl_rsvd[0]` equal to bit 34.
- R5: `ctrl_dlc` is the raw 4-bit length code, sent MSB first. The number of data bytes is the code value, limited to 8.
- R6: Each data byte, received MSB first, pulses `data_valid` once. `data_idx` counts 0 for the first byte after the length code.
- R7: The 15 bits after the last data bit are reported, MSB first, on `crc_seq` with a `crc_valid` pulse.
- R8: The bit after the CRC delimiter pulses `ack_valid`. `ack_ok` is 1 when that slot is dominant and 0 when it is recessive.
- R9: A dominant level on the CRC delimiter, the ACK delimiter or any of the seven end-of-frame bits pulses `err_form`. Parsing continues.
- R10: `frame_done` pulses after the seventh end-of-frame bit. The bit after that is treated as a start bit.
- R11: From the start bit through the last CRC bit, a raw bit that follows five equal raw bits is a stuff bit. This includes one such bit directly after the CRC. A stuff bit is removed and is not counted as a frame bit. No stuffing is applied from the CRC delimiter onward.
- R12: A stuff bit at the same level as the five bits before it pulses `err_stuff`. The frame is abandoned and the parser waits for a new start bit.
- R13: Every strobe is registered: it rises in the cycle after the clock edge that accepts the completing bit. At most one field strobe is high in any cycle. Cycles with `bit_valid` low change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_valid | input | 1 | A sampled bus bit is present this cycle |
| bit_val | input | 1 | Sampled bus level, 0 dominant, 1 recessive |
| id_valid | output | 1 | Base identifier strobe |
| base_id | output | 11 | Base identifier |
| ext_valid | output | 1 | Extended identifier strobe |
| ext_id | output | 18 | Extended identifier part |
| full_id | output | 29 | Combined 29-bit identifier |
| ctrl_valid | output | 1 | Control field strobe |
| ctrl_rtr | output | 1 | Remote request bit |
| ctrl_ide | output | 1 | Format bit, 1 extended |
| ctrl_dlc | output | 4 | Raw length code |
| ctrl_rsvd | output | 2 | Reserved bits: [0] last reserved bit, [1] extended-only bit |
| data_valid | output | 1 | Data byte strobe |
| data_idx | output | 3 | Index of the data byte |
| data_byte | output | 8 | Data byte value |
| crc_valid | output | 1 | CRC sequence strobe |
| crc_seq | output | 15 | Received CRC sequence |
| ack_valid | output | 1 | ACK slot strobe |
| ack_ok | output | 1 | 1 if the ACK slot was dominant |
| frame_done | output | 1 | End of frame reached |
| err_sof | output | 1 | Recessive start bit seen |
| err_stuff | output | 1 | Stuffing rule broken |
| err_form | output | 1 | Dominant fixed-form bit |

## Verification
Almost every internal fault moves the position counter. A miscounted position, a stuff bit that is kept or a valid bit that is dropped shows at the ports within one field. The identifier or length value comes out shifted, or the strobe lands on the wrong bit. The error then carries into a wrong byte count and a CRC and ACK read from the wrong bits. A wrong format bit or a wrong length clamp changes where `frame_done` fires. The next frame's start bit is then misread, so the fault also shows as a missing or corrupted next frame. The bench uses stuff-heavy payloads, idle gaps with a toggling bus level, and back-to-back frames after each error, so that these slips reach the ports.

// File: rtl/can_fp_pkg.sv
// Shared widths, frame positions and phase type for the CAN field parser.
// Assumes frame bit 0 is the start bit; positions count unstuffed bits.
package can_fp_pkg;
    localparam int BASE_W    = 11;
    localparam int EXT_W     = 18;
    localparam int FULL_W    = BASE_W + EXT_W;
    localparam int DLC_W     = 4;
    localparam int CRC_W     = 15;
    localparam int BYTE_W    = 8;
    localparam int MAX_BYTES = 8;
    localparam int IDX_W     = $clog2(MAX_BYTES);
    localparam int RUN_MAX   = 5;
    localparam int RUN_W     = $clog2(RUN_MAX + 1);
    localparam int EOF_LEN   = 7;
    localparam int EXT_HDR_LAST = 38;
    localparam int TAIL_LAST    = CRC_W + 3 + EOF_LEN;
    localparam int POS_W     = $clog2(EXT_HDR_LAST + MAX_BYTES * BYTE_W + TAIL_LAST + 1);

    typedef logic [POS_W-1:0] pos_t;
    typedef logic [IDX_W:0]   cnt_t;

    // Absolute header positions
    localparam pos_t P_ID_LAST    = pos_t'(11);
    localparam pos_t P_BIT12      = pos_t'(12);
    localparam pos_t P_IDE        = pos_t'(13);
    localparam pos_t P_STD_RB0    = pos_t'(14);
    localparam pos_t P_STD_DLC0   = pos_t'(15);
    localparam pos_t P_STD_DLC3   = pos_t'(18);
    localparam pos_t P_EXT_ID0    = pos_t'(14);
    localparam pos_t P_EXT_IDL    = pos_t'(31);
    localparam pos_t P_EXT_RTR    = pos_t'(32);
    localparam pos_t P_EXT_RB1    = pos_t'(33);
    localparam pos_t P_EXT_RB0    = pos_t'(34);
    localparam pos_t P_EXT_DLC0   = pos_t'(35);
    localparam pos_t P_EXT_DLC3   = pos_t'(EXT_HDR_LAST);

    // Offsets relative to the last data bit
    localparam pos_t R_CRC_LAST   = pos_t'(CRC_W);
    localparam pos_t R_CRC_DEL    = pos_t'(CRC_W + 1);
    localparam pos_t R_ACK        = pos_t'(CRC_W + 2);
    localparam pos_t R_ACK_DEL    = pos_t'(CRC_W + 3);
    localparam pos_t R_EOF_LAST   = pos_t'(TAIL_LAST);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HEAD,
        PH_DATA,
        PH_CRC,
        PH_TAIL
    } phase_t;
endpackage

// File: rtl/can_destuffer.sv
// Removes stuff bits from the raw bit stream and flags stuffing violations.
// Assumes: en is high while stuffing applies; restart is high while the
// next accepted bit is a start bit, which opens a fresh run.
module can_destuffer
    import can_fp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_bit,
    input  logic en,
    input  logic restart,
    output logic out_valid,
    output logic out_bit,
    output logic stuff_err
);
    logic             prev_q;
    logic [RUN_W-1:0] run_q;
    logic             is_stuff;

    // Classify the current raw bit as frame bit or stuff bit.
    always_comb begin
        is_stuff  = in_valid && en && !restart && (run_q == RUN_W'(RUN_MAX));
        out_valid = in_valid && !is_stuff;
        out_bit   = in_bit;
        stuff_err = is_stuff && (in_bit == prev_q);
    end

    // Track the level and length of the current run of equal raw bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            run_q  <= '0;
        end else if (in_valid) begin
            if (restart || is_stuff || in_bit != prev_q) begin
                prev_q <= in_bit;
                run_q  <= RUN_W'(1);
            end else if (run_q != RUN_W'(RUN_MAX)) begin
                run_q  <= run_q + RUN_W'(1);
            end
        end
    end

    assert_run_bounded_R11: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_W'(RUN_MAX));

endmodule

// File: rtl/can_frame_tracker.sv
// Counts unstuffed frame bits and walks the frame phases. It latches the
// format bit and the length code, and derives the index of the last data bit.
// Assumes one frame bit per dv pulse; a stuffing error aborts to idle.
module can_frame_tracker
    import can_fp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dv,
    input  logic             db,
    input  logic             stuff_err,
    output phase_t           phase,
    output pos_t             pos,
    output pos_t             last_q,
    output logic             ide_q,
    output logic [DLC_W-1:0] dlc_sh,
    output cnt_t             nbytes,
    output logic             stuff_en,
    output logic             restart
);
    pos_t             rel;
    pos_t             dlc_first;
    pos_t             dlc_last;
    logic [DLC_W-1:0] dlc_full;
    cnt_t             nb;

    // Derive the header layout and the clamped byte count from state.
    always_comb begin
        rel       = pos - last_q;
        dlc_first = ide_q ? P_EXT_DLC0 : P_STD_DLC0;
        dlc_last  = ide_q ? P_EXT_DLC3 : P_STD_DLC3;
        dlc_full  = {dlc_sh[DLC_W-2:0], db};
        nb        = (dlc_full > DLC_W'(MAX_BYTES)) ? cnt_t'(MAX_BYTES) : cnt_t'(dlc_full);
        stuff_en  = (phase != PH_TAIL) || (rel == R_CRC_DEL);
        restart   = (phase == PH_IDLE);
    end

    // Advance position and phase on every accepted frame bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            pos    <= '0;
            last_q <= '0;
            ide_q  <= 1'b0;
            dlc_sh <= '0;
            nbytes <= '0;
        end else if (stuff_err) begin
            phase <= PH_IDLE;
            pos   <= '0;
        end else if (dv) begin
            case (phase)
                PH_IDLE: begin
                    if (!db) begin
                        phase <= PH_HEAD;
                        pos   <= pos_t'(1);
                    end
                end
                PH_HEAD: begin
                    pos <= pos + pos_t'(1);
                    if (pos == P_IDE) ide_q <= db;
                    if (pos >= dlc_first && pos <= dlc_last) dlc_sh <= dlc_full;
                    if (pos == dlc_last) begin
                        last_q <= dlc_last + (pos_t'(nb) << 3);
                        nbytes <= nb;
                        phase  <= (nb == '0) ? PH_CRC : PH_DATA;
                    end
                end
                PH_DATA: begin
                    pos <= pos + pos_t'(1);
                    if (pos == last_q) phase <= PH_CRC;
                end
                PH_CRC: begin
                    pos <= pos + pos_t'(1);
                    if (rel == R_CRC_LAST) phase <= PH_TAIL;
                end
                PH_TAIL: begin
                    if (rel == R_EOF_LAST) begin
                        phase <= PH_IDLE;
                        pos   <= '0;
                    end else begin
                        pos <= pos + pos_t'(1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assert_abort_to_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        stuff_err |=> (phase == PH_IDLE));

endmodule

// File: rtl/can_field_extract.sv
// Shifts frame bits into field registers and raises registered field and
// error strobes. Assumes the tracker's phase and position describe the
// bit presented on dv/db in the same cycle.
module can_field_extract
    import can_fp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dv,
    input  logic              db,
    input  logic              stuff_err,
    input  phase_t            phase,
    input  pos_t              pos,
    input  pos_t              last_q,
    input  logic              ide_q,
    input  logic [DLC_W-1:0]  dlc_sh,
    input  cnt_t              nbytes,
    output logic              id_valid,
    output logic [BASE_W-1:0] base_id,
    output logic              ext_valid,
    output logic [EXT_W-1:0]  ext_id,
    output logic [FULL_W-1:0] full_id,
    output logic              ctrl_valid,
    output logic              ctrl_rtr,
    output logic              ctrl_ide,
    output logic [DLC_W-1:0]  ctrl_dlc,
    output logic [1:0]        ctrl_rsvd,
    output logic              data_valid,
    output logic [IDX_W-1:0]  data_idx,
    output logic [BYTE_W-1:0] data_byte,
    output logic              crc_valid,
    output logic [CRC_W-1:0]  crc_seq,
    output logic              ack_valid,
    output logic              ack_ok,
    output logic              frame_done,
    output logic              err_sof,
    output logic              err_stuff,
    output logic              err_form
);
    logic [BASE_W-1:0] id_sh;
    logic [EXT_W-1:0]  eid_sh;
    logic [BYTE_W-1:0] byte_sh;
    logic [CRC_W-1:0]  crc_sh;
    logic              b12_q, rtr_e_q, rb1_q, rb0_q;
    pos_t              rel, off, data_first, dlc_last, rb0_pos;

    // Offsets of the current bit inside the data and trailer fields.
    always_comb begin
        rel        = pos - last_q;
        dlc_last   = ide_q ? P_EXT_DLC3 : P_STD_DLC3;
        rb0_pos    = ide_q ? P_EXT_RB0 : P_STD_RB0;
        data_first = dlc_last + pos_t'(1);
        off        = pos - data_first;
    end

    // Capture field bits and pulse the strobe of each completed field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_sh <= '0; eid_sh <= '0; byte_sh <= '0; crc_sh <= '0;
            b12_q <= 1'b0; rtr_e_q <= 1'b0; rb1_q <= 1'b0; rb0_q <= 1'b0;
            id_valid <= 1'b0; base_id <= '0;
            ext_valid <= 1'b0; ext_id <= '0; full_id <= '0;
            ctrl_valid <= 1'b0; ctrl_rtr <= 1'b0; ctrl_ide <= 1'b0;
            ctrl_dlc <= '0; ctrl_rsvd <= '0;
            data_valid <= 1'b0; data_idx <= '0; data_byte <= '0;
            crc_valid <= 1'b0; crc_seq <= '0;
            ack_valid <= 1'b0; ack_ok <= 1'b0;
            frame_done <= 1'b0; err_sof <= 1'b0; err_stuff <= 1'b0; err_form <= 1'b0;
        end else begin
            id_valid   <= 1'b0;
            ext_valid  <= 1'b0;
            ctrl_valid <= 1'b0;
            data_valid <= 1'b0;
            crc_valid  <= 1'b0;
            ack_valid  <= 1'b0;
            frame_done <= 1'b0;
            err_sof    <= 1'b0;
            err_form   <= 1'b0;
            err_stuff  <= stuff_err;
            if (dv) begin
                case (phase)
                    PH_IDLE: begin
                        if (db) err_sof <= 1'b1;
                    end
                    PH_HEAD: begin
                        if (pos <= P_ID_LAST) id_sh <= {id_sh[BASE_W-2:0], db};
                        if (pos == P_ID_LAST) begin
                            id_valid <= 1'b1;
                            base_id  <= {id_sh[BASE_W-2:0], db};
                        end
                        if (pos == P_BIT12) b12_q <= db;
                        if (ide_q && pos >= P_EXT_ID0 && pos <= P_EXT_IDL)
                            eid_sh <= {eid_sh[EXT_W-2:0], db};
                        if (ide_q && pos == P_EXT_IDL) begin
                            ext_valid <= 1'b1;
                            ext_id    <= {eid_sh[EXT_W-2:0], db};
                            full_id   <= {base_id, eid_sh[EXT_W-2:0], db};
                        end
                        if (ide_q && pos == P_EXT_RTR) rtr_e_q <= db;
                        if (ide_q && pos == P_EXT_RB1) rb1_q <= db;
                        if (pos == rb0_pos) rb0_q <= db;
                        if (pos == dlc_last) begin
                            ctrl_valid <= 1'b1;
                            ctrl_ide   <= ide_q;
                            ctrl_rtr   <= ide_q ? rtr_e_q : b12_q;
                            ctrl_dlc   <= {dlc_sh[DLC_W-2:0], db};
                            ctrl_rsvd  <= {ide_q & rb1_q, rb0_q};
                        end
                    end
                    PH_DATA: begin
                        byte_sh <= {byte_sh[BYTE_W-2:0], db};
                        if (off[2:0] == 3'd7) begin
                            data_valid <= 1'b1;
                            data_idx   <= off[IDX_W+2:3];
                            data_byte  <= {byte_sh[BYTE_W-2:0], db};
                        end
                    end
                    PH_CRC: begin
                        crc_sh <= {crc_sh[CRC_W-2:0], db};
                        if (rel == R_CRC_LAST) begin
                            crc_valid <= 1'b1;
                            crc_seq   <= {crc_sh[CRC_W-2:0], db};
                        end
                    end
                    PH_TAIL: begin
                        if (rel == R_ACK) begin
                            ack_valid <= 1'b1;
                            ack_ok    <= ~db;
                        end else if (!db) begin
                            err_form <= 1'b1;
                        end
                        if (rel == R_EOF_LAST) frame_done <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_single_strobe_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({id_valid, ext_valid, ctrl_valid, data_valid, crc_valid, ack_valid, frame_done}));

    assert_byte_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> ({1'b0, data_idx} < nbytes));

    assert_ext_only_extended_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ext_valid |-> ide_q);

endmodule

// File: rtl/can_field_parser.sv
// Top level: removes stuffing from a sampled CAN bit stream and decodes
// the fields of base and extended frames. Assumes bit_valid marks one
// sampled bus bit and the first bit after reset or a frame is a start bit.
module can_field_parser
    import can_fp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bit_valid,
    input  logic        bit_val,
    output logic        id_valid,
    output logic [10:0] base_id,
    output logic        ext_valid,
    output logic [17:0] ext_id,
    output logic [28:0] full_id,
    output logic        ctrl_valid,
    output logic        ctrl_rtr,
    output logic        ctrl_ide,
    output logic [3:0]  ctrl_dlc,
    output logic [1:0]  ctrl_rsvd,
    output logic        data_valid,
    output logic [2:0]  data_idx,
    output logic [7:0]  data_byte,
    output logic        crc_valid,
    output logic [14:0] crc_seq,
    output logic        ack_valid,
    output logic        ack_ok,
    output logic        frame_done,
    output logic        err_sof,
    output logic        err_stuff,
    output logic        err_form
);
    logic             dv, db, stuff_err, stuff_en, restart, ide_q;
    phase_t           phase;
    pos_t             pos, last_q;
    logic [DLC_W-1:0] dlc_sh;
    cnt_t             nbytes;

    can_destuffer u_destuff (
        .clk(clk), .rst_n(rst_n),
        .in_valid(bit_valid), .in_bit(bit_val),
        .en(stuff_en), .restart(restart),
        .out_valid(dv), .out_bit(db), .stuff_err(stuff_err)
    );

    can_frame_tracker u_track (
        .clk(clk), .rst_n(rst_n),
        .dv(dv), .db(db), .stuff_err(stuff_err),
        .phase(phase), .pos(pos), .last_q(last_q), .ide_q(ide_q),
        .dlc_sh(dlc_sh), .nbytes(nbytes),
        .stuff_en(stuff_en), .restart(restart)
    );

    can_field_extract u_extract (
        .clk(clk), .rst_n(rst_n),
        .dv(dv), .db(db), .stuff_err(stuff_err),
        .phase(phase), .pos(pos), .last_q(last_q), .ide_q(ide_q),
        .dlc_sh(dlc_sh), .nbytes(nbytes),
        .id_valid(id_valid), .base_id(base_id),
        .ext_valid(ext_valid), .ext_id(ext_id), .full_id(full_id),
        .ctrl_valid(ctrl_valid), .ctrl_rtr(ctrl_rtr), .ctrl_ide(ctrl_ide),
        .ctrl_dlc(ctrl_dlc), .ctrl_rsvd(ctrl_rsvd),
        .data_valid(data_valid), .data_idx(data_idx), .data_byte(data_byte),
        .crc_valid(crc_valid), .crc_seq(crc_seq),
        .ack_valid(ack_valid), .ack_ok(ack_ok),
        .frame_done(frame_done),
        .err_sof(err_sof), .err_stuff(err_stuff), .err_form(err_form)
    );

    assert_done_returns_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (phase == PH_IDLE));

    assert_stuff_err_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        err_stuff |-> (phase == PH_IDLE));

endmodule

// File: tb/can_field_parser_tb.sv
// Bench: walks a table of frames (built and stuffed here), then directed
// tests for reset, start-bit, stuffing and form errors.
module can_field_parser_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_valid = 1'b0;
    logic        bit_val = 1'b1;
    logic        id_valid, ext_valid, ctrl_valid, ctrl_rtr, ctrl_ide;
    logic        data_valid, crc_valid, ack_valid, ack_ok, frame_done;
    logic        err_sof, err_stuff, err_form;
    logic [10:0] base_id;
    logic [17:0] ext_id;
    logic [28:0] full_id;
    logic [3:0]  ctrl_dlc;
    logic [1:0]  ctrl_rsvd;
    logic [2:0]  data_idx;
    logic [7:0]  data_byte;
    logic [14:0] crc_seq;

    always #10 clk = ~clk;

    can_field_parser u_dut (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_val(bit_val),
        .id_valid(id_valid), .base_id(base_id),
        .ext_valid(ext_valid), .ext_id(ext_id), .full_id(full_id),
        .ctrl_valid(ctrl_valid), .ctrl_rtr(ctrl_rtr), .ctrl_ide(ctrl_ide),
        .ctrl_dlc(ctrl_dlc), .ctrl_rsvd(ctrl_rsvd),
        .data_valid(data_valid), .data_idx(data_idx), .data_byte(data_byte),
        .crc_valid(crc_valid), .crc_seq(crc_seq),
        .ack_valid(ack_valid), .ack_ok(ack_ok), .frame_done(frame_done),
        .err_sof(err_sof), .err_stuff(err_stuff), .err_form(err_form)
    );

    // {ext, rtr, rsvd[1:0], dlc[3:0], id[28:0], data[63:0], crc[14:0], ack}
    localparam logic [116:0] VECS [0:4] = '{
        {1'b0, 1'b0, 2'b00, 4'd2,  29'h00000123, 64'hABCD_0000_0000_0000, 15'h1234, 1'b1},
        {1'b0, 1'b1, 2'b01, 4'd0,  29'h000007F0, 64'h0,                   15'h7FFF, 1'b0},
        {1'b1, 1'b0, 2'b11, 4'd8,  29'h0ABCDEF1, 64'h0000_0000_FFFF_FFFF, 15'h0000, 1'b1},
        {1'b1, 1'b1, 2'b00, 4'd0,  29'h1FFFFFFF, 64'h0,                   15'h2AAA, 1'b1},
        {1'b0, 1'b0, 2'b00, 4'd12, 29'h00000000, 64'h0123_4567_89AB_CDEF, 15'h0001, 1'b1}
    };

    int n_chk = 0, n_bad = 0;
    int n_id, n_ext, n_ctrl, n_data, n_crc, n_ack, n_done, n_sof, n_stf, n_form, n_multi;
    logic [10:0] c_id;
    logic [17:0] c_ext;
    logic [28:0] c_full;
    logic        c_rtr, c_ide, c_ack;
    logic [3:0]  c_dlc;
    logic [1:0]  c_rsv;
    logic [14:0] c_crc;
    logic [7:0]  c_data [0:7];
    logic        fbits [0:127];
    int          fn;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_caps();
        n_id = 0; n_ext = 0; n_ctrl = 0; n_data = 0; n_crc = 0; n_ack = 0;
        n_done = 0; n_sof = 0; n_stf = 0; n_form = 0; n_multi = 0;
        for (int i = 0; i < 8; i++) c_data[i] = 8'h00;
    endtask

    task automatic sample();
        int s;
        s = int'(id_valid) + int'(ext_valid) + int'(ctrl_valid) + int'(data_valid)
          + int'(crc_valid) + int'(ack_valid) + int'(frame_done);
        if (s > 1) n_multi++;
        if (id_valid)   begin n_id++; c_id = base_id; end
        if (ext_valid)  begin n_ext++; c_ext = ext_id; c_full = full_id; end
        if (ctrl_valid) begin n_ctrl++; c_rtr = ctrl_rtr; c_ide = ctrl_ide; c_dlc = ctrl_dlc; c_rsv = ctrl_rsvd; end
        if (data_valid) begin n_data++; c_data[data_idx] = data_byte; end
        if (crc_valid)  begin n_crc++; c_crc = crc_seq; end
        if (ack_valid)  begin n_ack++; c_ack = ack_ok; end
        if (frame_done) n_done++;
        if (err_sof)    n_sof++;
        if (err_stuff)  n_stf++;
        if (err_form)   n_form++;
    endtask

    // One raw bit, then 'gap' idle cycles with the opposite level (R13).
    task automatic send_bit(input logic v, input int gap);
        bit_valid = 1'b1; bit_val = v;
        @(negedge clk);
        bit_valid = 1'b0; bit_val = ~v;
        sample();
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            sample();
        end
    endtask

    task automatic put_bit(input logic b);
        fbits[fn] = b;
        fn++;
    endtask

    task automatic send_frame(input logic ext, input logic rtr, input logic [1:0] rsv,
                              input logic [3:0] dlc, input logic [28:0] id,
                              input logic [63:0] data, input logic [14:0] crc,
                              input logic ack, input logic bad_del, input int gap);
        logic [10:0] base;
        logic        prev;
        int          run, nb;
        base = ext ? id[28:18] : id[10:0];
        nb = (dlc > 4'd8) ? 8 : int'(dlc);
        fn = 0;
        put_bit(1'b0);
        for (int i = 10; i >= 0; i--) put_bit(base[i]);
        put_bit(ext ? 1'b1 : rtr);
        put_bit(ext);
        if (ext) begin
            for (int i = 17; i >= 0; i--) put_bit(id[i]);
            put_bit(rtr); put_bit(rsv[1]); put_bit(rsv[0]);
        end else begin
            put_bit(rsv[0]);
        end
        for (int i = 3; i >= 0; i--) put_bit(dlc[i]);
        for (int b = 0; b < nb; b++)
            for (int k = 7; k >= 0; k--) put_bit(data[63 - 8*b - (7 - k)]);
        for (int i = 14; i >= 0; i--) put_bit(crc[i]);
        prev = 1'b0; run = 0;
        for (int i = 0; i < fn; i++) begin
            send_bit(fbits[i], gap);
            if (i == 0 || fbits[i] != prev) begin prev = fbits[i]; run = 1; end
            else run++;
            if (run == 5) begin
                send_bit(~prev, gap);
                prev = ~prev; run = 1;
            end
        end
        send_bit(~bad_del, gap);
        send_bit(~ack, gap);
        send_bit(1'b1, gap);
        for (int i = 0; i < 7; i++) send_bit(1'b1, gap);
    endtask

    task automatic check_frame(input logic ext, input logic rtr, input logic [1:0] rsv,
                               input logic [3:0] dlc, input logic [28:0] id,
                               input logic [63:0] data, input logic [14:0] crc,
                               input logic ack, input int exp_form);
        int nb;
        nb = (dlc > 4'd8) ? 8 : int'(dlc);
        check("R2 id count", 64'(n_id), 64'd1);
        check("R2 base id", 64'(c_id), 64'(ext ? id[28:18] : id[10:0]));
        if (ext) begin
            check("R4 ext count", 64'(n_ext), 64'd1);
            check("R4 ext id", 64'(c_ext), 64'(id[17:0]));
            check("R4 full id", 64'(c_full), 64'(id));
        end else begin
            check("R3 no ext strobe", 64'(n_ext), 64'd0);
        end
        check("R3 ctrl count", 64'(n_ctrl), 64'd1);
        check("R3 ide", 64'(c_ide), 64'(ext));
        check("R3 rtr", 64'(c_rtr), 64'(rtr));
        check("R3 rsvd", 64'(c_rsv), 64'(ext ? rsv : {1'b0, rsv[0]}));
        check("R5 dlc", 64'(c_dlc), 64'(dlc));
        check("R5 byte count", 64'(n_data), 64'(nb));
        for (int b = 0; b < nb; b++)
            check("R6 data byte", 64'(c_data[b]), 64'(data[63 - 8*b -: 8]));
        check("R7 crc count", 64'(n_crc), 64'd1);
        check("R7 crc", 64'(c_crc), 64'(crc));
        check("R8 ack", 64'(c_ack), 64'(ack));
        check("R10 done", 64'(n_done), 64'd1);
        check("R9 form errors", 64'(n_form), 64'(exp_form));
        check("R11 no stuff error", 64'(n_stf), 64'd0);
        check("R1 no sof error", 64'(n_sof), 64'd0);
        check("R13 single strobe", 64'(n_multi), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R10 watchdog: actual hung expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [116:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state, all strobes low
        check("R1 reset strobes", 64'({id_valid, ext_valid, ctrl_valid, data_valid, crc_valid,
              ack_valid, frame_done, err_sof, err_stuff, err_form}), 64'd0);

        // Table walk: gap varies to exercise ignored idle cycles (R13)
        for (int i = 0; i < 5; i++) begin
            v = VECS[i];
            clear_caps();
            send_frame(v[116], v[115], v[114:113], v[112:109], v[108:80], v[79:16],
                       v[15:1], v[0], 1'b0, i % 3);
            check_frame(v[116], v[115], v[114:113], v[112:109], v[108:80], v[79:16],
                        v[15:1], v[0], 0);
        end

        // R1: recessive in start position is flagged and discarded
        clear_caps();
        send_bit(1'b1, 1);
        check("R1 sof error", 64'(n_sof), 64'd1);
        check("R1 no id after bad sof", 64'(n_id), 64'd0);
        v = VECS[0];
        clear_caps();
        send_frame(v[116], v[115], v[114:113], v[112:109], v[108:80], v[79:16], v[15:1], v[0], 1'b0, 0);
        check_frame(v[116], v[115], v[114:113], v[112:109], v[108:80], v[79:16], v[15:1], v[0], 0);

        // R12: sixth equal bit where a stuff bit is due
        clear_caps();
        for (int i = 0; i < 6; i++) send_bit(1'b0, 0);
        check("R12 stuff error", 64'(n_stf), 64'd1);
        check("R12 no id after abort", 64'(n_id), 64'd0);
        v = VECS[2];
        clear_caps();
        send_frame(v[116], v[115], v[114:113], v[112:109], v[108:80], v[79:16], v[15:1], v[0], 1'b0, 1);
        check_frame(v[116], v[115], v[114:113], v[112:109], v[108:80], v[79:16], v[15:1], v[0], 0);

        // R9: dominant CRC delimiter flags a form error, frame still completes
        v = VECS[4];
        clear_caps();
        send_frame(v[116], v[115], v[114:113], v[112:109], v[108:80], v[79:16], v[15:1], v[0], 1'b1, 0);
        check_frame(v[116], v[115], v[114:113], v[112:109], v[108:80], v[79:16], v[15:1], v[0], 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule